// File: doc/BRIEF.md
# ATAPI Packet PIO Transfer Sequencer

This block is the device side of a packet command whose data moves by programmed I/O. The host first programs a 16-bit transfer limit through two byte registers and writes the packet opcode to the command register. The device then accepts a 12-byte command packet as six 16-bit writes to the data register. It decodes a READ(10) request and returns the requested 2048-byte logical blocks as 16-bit words read from the data register.

The data phase is cut into chunks. No chunk is larger than the transfer limit rounded down to an even byte count, and the last chunk carries whatever remains. The device raises an interrupt before each chunk. After the final chunk has drained it raises one more interrupt to report completion. A read of the status register acknowledges a pending interrupt. Block contents come from a pattern-filled block store that is computed from the logical block address and the word position within the block.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status byte (offset 7) reads 0x40 (ready only) and the interrupt output is low.
- R2: Writing 0xA0 to offset 7 while idle makes status read 0x48 (DRQ bit 3 and ready bit 6) with no interrupt, awaiting the packet. Any other command value leaves status at 0x40 and the interrupt low.
- R3: The packet is six 16-bit writes to offset 0. Word k carries byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Byte 0 is the opcode (0x28 = read). Bytes 2..5 are the block address, most significant byte first. Bytes 7..8 are the block count, most significant byte first.
- R4: Each read of offset 0 during a chunk returns the next data word and advances. Word w of block b reads as the low 16 bits of {b, w[9:0]} XOR 0x5A3C. The block address increments after word 1023.
- R5: The limit is written with its low byte at offset 4 and its high byte at offset 5. Each chunk holds min(limit with bit 0 cleared, remaining bytes) bytes.
- R6: A limit of zero is treated as 0xFFFE bytes.
- R7: Before each chunk the interrupt is asserted and status reads 0x48. Between chunks status reads 0xC0 (busy bit 7 and ready), and busy is never shown together with DRQ.
- R8: After the last chunk one further interrupt is raised and status then reads 0x40.
- R9: A status read while not busy deasserts the interrupt on the next cycle.
- R10: A block count of zero, or an opcode other than 0x28, produces no data phase: only the completion interrupt, with status 0x40.
- R11: Command writes made while a transfer is in progress are ignored; the chunk continues with status 0x48 and the same data sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Register offset of the host access |
| hostWrEn | input | 1 | Host write strobe, one cycle per access |
| hostWrData | input | 16 | Host write data |
| hostRdEn | input | 1 | Host read strobe, one cycle per access |
| hostRdData | output | 16 | Read data for the current offset (combinational) |
| irq | output | 1 | Device interrupt request |

## Verification
The hardest case to reach is a chunk that is clipped by the limit rather than by the data remaining. With the zero-limit encoding this needs more than 32767 words of data. The stimulus reaches it by requesting 33 blocks, so that a 32767-word chunk is followed by a 1025-word tail. A second odd-limit transfer starts at block 62 so that the block address crosses the 64-block pattern wrap inside a chunk. In the middle of that chunk the stimulus also injects a stray command write to confirm that the data stream is unaffected.

// File: rtl/atapi_pio_pkg.sv
package atapi_pio_pkg;

  localparam int LBA_W   = 32;
  localparam int COUNT_W = 16;
  localparam int LIMIT_W = 16;

  localparam logic [2:0] OFS_DATA   = 3'd0;
  localparam logic [2:0] OFS_LIM_LO = 3'd4;
  localparam logic [2:0] OFS_LIM_HI = 3'd5;
  localparam logic [2:0] OFS_CMDSTS = 3'd7;

  localparam logic [7:0] OPC_PACKET = 8'hA0;
  localparam logic [7:0] OPC_READ10 = 8'h28;

  localparam logic [7:0] STS_BUSY  = 8'h80;
  localparam logic [7:0] STS_READY = 8'h40;
  localparam logic [7:0] STS_DRQ   = 8'h08;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_PKT,
    SEQ_DECODE,
    SEQ_PREP,
    SEQ_CHUNK
  } seqState_t;

  typedef struct packed {
    logic pktClear;
    logic pktCapture;
    logic xferLoad;
    logic chunkLoad;
    logic wordAdvance;
  } seqStrobes_t;

endpackage

// File: rtl/atapi_pio_ctrl.sv
module atapi_pio_ctrl
  import atapi_pio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  hostAddr,
  input  logic        hostWrEn,
  input  logic [7:0]  hostWrByte,
  input  logic        hostRdEn,
  input  logic        pktLast,
  input  logic        xferEmpty,
  input  logic        chunkLast,
  output seqStrobes_t strobes,
  output logic        seqIdle,
  output logic        seqInChunk,
  output logic [7:0]  statusByte,
  output logic        irq
);

  seqState_t state, stateNext;
  logic      raiseIrq;
  logic      statusRead;

  assign statusRead = hostRdEn && (hostAddr == OFS_CMDSTS);

  always_comb begin
    stateNext = state;
    strobes   = '0;
    raiseIrq  = 1'b0;
    case (state)
      SEQ_IDLE: begin
        if (hostWrEn && hostAddr == OFS_CMDSTS && hostWrByte == OPC_PACKET) begin
          strobes.pktClear = 1'b1;
          stateNext        = SEQ_PKT;
        end
      end
      SEQ_PKT: begin
        if (hostWrEn && hostAddr == OFS_DATA) begin
          strobes.pktCapture = 1'b1;
          if (pktLast) stateNext = SEQ_DECODE;
        end
      end
      SEQ_DECODE: begin
        strobes.xferLoad = 1'b1;
        stateNext        = SEQ_PREP;
      end
      SEQ_PREP: begin
        raiseIrq = 1'b1;
        if (xferEmpty) begin
          stateNext = SEQ_IDLE;
        end else begin
          strobes.chunkLoad = 1'b1;
          stateNext         = SEQ_CHUNK;
        end
      end
      SEQ_CHUNK: begin
        if (hostRdEn && hostAddr == OFS_DATA) begin
          strobes.wordAdvance = 1'b1;
          if (chunkLast) stateNext = SEQ_PREP;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      irq   <= 1'b0;
    end else begin
      state <= stateNext;
      if (raiseIrq)        irq <= 1'b1;
      else if (statusRead) irq <= 1'b0;
    end
  end

  always_comb begin
    case (state)
      SEQ_PKT, SEQ_CHUNK:   statusByte = STS_READY | STS_DRQ;
      SEQ_DECODE, SEQ_PREP: statusByte = STS_READY | STS_BUSY;
      default:              statusByte = STS_READY;
    endcase
  end

  assign seqIdle    = (state == SEQ_IDLE);
  assign seqInChunk = (state == SEQ_CHUNK);

endmodule

// File: rtl/atapi_pio_dpath.sv
module atapi_pio_dpath
  import atapi_pio_pkg::*;
#(
  parameter int          BLOCK_BYTES = 2048,
  parameter logic [15:0] DATA_SEED   = 16'h5A3C
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         hostAddr,
  input  logic               hostWrEn,
  input  logic [15:0]        hostWrData,
  input  seqStrobes_t        strobes,
  input  logic               seqIdle,
  input  logic               seqInChunk,
  output logic               pktLast,
  output logic               xferEmpty,
  output logic               chunkLast,
  output logic [LIMIT_W-1:0] limitReg,
  output logic [15:0]        dataWord
);

  localparam int WORDS_PER_BLK = BLOCK_BYTES / 2;
  localparam int WIDX_W        = $clog2(WORDS_PER_BLK);
  localparam int REM_W         = COUNT_W + WIDX_W;
  localparam int CHUNK_W       = LIMIT_W - 1;
  localparam int PKT_WORDS     = 6;

  logic [2:0]         pktIdx;
  logic [7:0]         pktOpc;
  logic [LBA_W-1:0]   pktLba;
  logic [COUNT_W-1:0] pktCnt;

  logic [LBA_W-1:0]   curLba;
  logic [WIDX_W-1:0]  wordIdx;
  logic [REM_W-1:0]   remWords;
  logic [CHUNK_W-1:0] chunkLeft;
  logic [CHUNK_W-1:0] limitWords;

  // limit registers accept writes only between commands
  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitReg <= '0;
    end else if (hostWrEn && seqIdle) begin
      if (hostAddr == OFS_LIM_LO) limitReg[7:0]  <= hostWrData[7:0];
      if (hostAddr == OFS_LIM_HI) limitReg[15:8] <= hostWrData[7:0];
    end
  end

  // packet capture: little-endian word lanes, big-endian multi-byte fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktIdx <= '0;
      pktOpc <= '0;
      pktLba <= '0;
      pktCnt <= '0;
    end else if (strobes.pktClear) begin
      pktIdx <= '0;
    end else if (strobes.pktCapture) begin
      pktIdx <= pktIdx + 3'd1;
      case (pktIdx)
        3'd0: pktOpc <= hostWrData[7:0];
        3'd1: pktLba[31:16] <= {hostWrData[7:0], hostWrData[15:8]};
        3'd2: pktLba[15:0]  <= {hostWrData[7:0], hostWrData[15:8]};
        3'd3: pktCnt[15:8]  <= hostWrData[15:8];
        3'd4: pktCnt[7:0]   <= hostWrData[7:0];
        default: ;
      endcase
    end
  end

  assign pktLast = (pktIdx == 3'(PKT_WORDS - 1));

  assign limitWords = (limitReg == '0) ? {CHUNK_W{1'b1}} : limitReg[LIMIT_W-1:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLba    <= '0;
      wordIdx   <= '0;
      remWords  <= '0;
      chunkLeft <= '0;
    end else if (strobes.xferLoad) begin
      curLba   <= pktLba;
      wordIdx  <= '0;
      remWords <= (pktOpc == OPC_READ10) ? {pktCnt, {WIDX_W{1'b0}}} : '0;
    end else if (strobes.chunkLoad) begin
      if (remWords < REM_W'(limitWords)) chunkLeft <= remWords[CHUNK_W-1:0];
      else                               chunkLeft <= limitWords;
    end else if (strobes.wordAdvance) begin
      chunkLeft <= chunkLeft - 1'b1;
      remWords  <= remWords - 1'b1;
      wordIdx   <= wordIdx + 1'b1;
      if (wordIdx == WIDX_W'(WORDS_PER_BLK - 1)) curLba <= curLba + 1'b1;
    end
  end

  assign xferEmpty = (remWords == '0);
  assign chunkLast = (chunkLeft == CHUNK_W'(1));

  // pattern-filled block store: content is a function of block and word
  assign dataWord = seqInChunk ? (16'({curLba, wordIdx}) ^ DATA_SEED) : 16'h0000;

endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
  import atapi_pio_pkg::*;
#(
  parameter int          BLOCK_BYTES = 2048,
  parameter logic [15:0] DATA_SEED   = 16'h5A3C
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  hostAddr,
  input  logic        hostWrEn,
  input  logic [15:0] hostWrData,
  input  logic        hostRdEn,
  output logic [15:0] hostRdData,
  output logic        irq
);

  seqStrobes_t        strobes;
  logic               seqIdle;
  logic               seqInChunk;
  logic               pktLast;
  logic               xferEmpty;
  logic               chunkLast;
  logic [7:0]         statusByte;
  logic [LIMIT_W-1:0] limitReg;
  logic [15:0]        dataWord;

  atapi_pio_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWrEn   (hostWrEn),
    .hostWrByte (hostWrData[7:0]),
    .hostRdEn   (hostRdEn),
    .pktLast    (pktLast),
    .xferEmpty  (xferEmpty),
    .chunkLast  (chunkLast),
    .strobes    (strobes),
    .seqIdle    (seqIdle),
    .seqInChunk (seqInChunk),
    .statusByte (statusByte),
    .irq        (irq)
  );

  atapi_pio_dpath #(
    .BLOCK_BYTES (BLOCK_BYTES),
    .DATA_SEED   (DATA_SEED)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .strobes    (strobes),
    .seqIdle    (seqIdle),
    .seqInChunk (seqInChunk),
    .pktLast    (pktLast),
    .xferEmpty  (xferEmpty),
    .chunkLast  (chunkLast),
    .limitReg   (limitReg),
    .dataWord   (dataWord)
  );

  always_comb begin
    case (hostAddr)
      OFS_DATA:   hostRdData = dataWord;
      OFS_LIM_LO: hostRdData = {8'h00, limitReg[7:0]};
      OFS_LIM_HI: hostRdData = {8'h00, limitReg[15:8]};
      OFS_CMDSTS: hostRdData = {8'h00, statusByte};
      default:    hostRdData = 16'h0000;
    endcase
  end

endmodule

// File: rtl/atapi_pio_checker.sv
module atapi_pio_checker (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  hostAddr,
  input logic        hostRdEn,
  input logic [15:0] hostRdData,
  input logic [7:0]  statusByte,
  input logic        irq
);

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    statusByte == 8'h40 || statusByte == 8'h48 || statusByte == 8'hC0); // R7

  AST_NO_BUSY_WITH_DRQ: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[7] && statusByte[3])); // R7

  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && hostAddr == 3'd7 && !statusByte[7]) |=> !irq); // R9

  AST_IRQ_FROM_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(statusByte) == 8'hC0); // R8

  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte == 8'h40 && hostRdEn && hostAddr == 3'd0) |-> hostRdData == 16'h0000); // R10

endmodule

bind atapi_pio_seq atapi_pio_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .hostAddr   (hostAddr),
  .hostRdEn   (hostRdEn),
  .hostRdData (hostRdData),
  .statusByte (statusByte),
  .irq        (irq)
);

// File: tb/atapi_pio_seq_bench.sv
`timescale 1ns/1ps
module atapi_pio_seq_bench;

  localparam logic [15:0] SEED = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  hostAddr = 3'd0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = 16'h0;
  logic        hostRdEn = 1'b0;
  logic [15:0] hostRdData;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  atapi_pio_seq u_atapi_pio_seq (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .hostRdEn   (hostRdEn),
    .hostRdData (hostRdData),
    .irq        (irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk);
    #1 hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostRdEn = 1'b1;
    #1 d = hostRdData;
    @(posedge clk);
    #1 hostRdEn = 1'b0;
  endtask

  task automatic waitIrq(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    check(req, {31'd0, seen}, 32'd1);
  endtask

  function automatic logic [15:0] expWord(input logic [31:0] lba, input int g);
    logic [31:0] blk;
    logic [9:0]  w;
    blk = lba + 32'(g / 1024);
    w   = 10'(g % 1024);
    return {blk[5:0], w} ^ SEED;
  endfunction

  task automatic runRead(input string tag, input logic [15:0] lim, input logic [31:0] lba,
                         input logic [15:0] cnt, input logic [7:0] opc, input bit inject);
    logic [15:0] rd;
    int remaining, effWords, n, g, bad, chunkNo;
    logic [15:0] firstAct, firstExp;
    hostWrite(3'd4, {8'h00, lim[7:0]});
    hostWrite(3'd5, {8'h00, lim[15:8]});
    hostWrite(3'd7, 16'h00A0);
    hostRead(3'd7, rd);
    check({"R2 packet wait status ", tag}, {16'd0, rd}, 32'h48);
    check({"R2 no irq at packet ", tag}, {31'd0, irq}, 32'd0);
    // R3 packet layout: word k = {byte 2k+1, byte 2k}
    hostWrite(3'd0, {8'h00, opc});
    hostWrite(3'd0, {lba[23:16], lba[31:24]});
    hostWrite(3'd0, {lba[7:0], lba[15:8]});
    hostWrite(3'd0, {cnt[15:8], 8'h00});
    hostWrite(3'd0, {8'h00, cnt[7:0]});
    hostWrite(3'd0, 16'h0000);
    remaining = (opc == 8'h28) ? int'(cnt) * 1024 : 0;
    effWords  = (lim == 16'h0) ? 32767 : int'(lim >> 1);
    g = 0;
    chunkNo = 0;
    while (remaining > 0) begin
      waitIrq({"R7 chunk irq ", tag});
      hostRead(3'd7, rd);
      check({"R7 chunk status ", tag}, {16'd0, rd}, 32'h48);
      check({"R9 irq acked ", tag}, {31'd0, irq}, 32'd0);
      n = (remaining < effWords) ? remaining : effWords;
      bad = 0;
      firstAct = '0;
      firstExp = '0;
      for (int i = 0; i < n; i++) begin
        if (inject && chunkNo == 0 && i == 100) begin
          hostWrite(3'd7, 16'h00A0);
          hostWrite(3'd7, 16'h00EC);
          hostRead(3'd7, rd);
          check({"R11 command ignored mid-chunk ", tag}, {16'd0, rd}, 32'h48);
        end
        hostRead(3'd0, rd);
        if (rd !== expWord(lba, g)) begin
          if (bad == 0) begin
            firstAct = rd;
            firstExp = expWord(lba, g);
          end
          bad++;
        end
        g++;
      end
      check({"R4 R5 chunk data ", tag}, {16'd0, (bad == 0) ? firstExp : firstAct}, {16'd0, firstExp});
      remaining -= n;
      chunkNo++;
    end
    waitIrq({"R8 completion irq ", tag});
    hostRead(3'd7, rd);
    check({"R8 final status ", tag}, {16'd0, rd}, 32'h40);
    check({"R9 final irq acked ", tag}, {31'd0, irq}, 32'd0);
  endtask

  task automatic testReset();
    logic [15:0] rd;
    hostRead(3'd7, rd);
    check("R1 reset status", {16'd0, rd}, 32'h40);
    check("R1 reset irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic testOtherCommand();
    logic [15:0] rd;
    hostWrite(3'd7, 16'h00EC);
    repeat (3) @(negedge clk);
    check("R2 other command irq", {31'd0, irq}, 32'd0);
    hostRead(3'd7, rd);
    check("R2 other command status", {16'd0, rd}, 32'h40);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOtherCommand();
    runRead("R5 one block", 16'd5120, 32'h0000_0007, 16'd1, 8'h28, 1'b0);
    runRead("R3 ten blocks", 16'd5120, 32'h0102_0304, 16'd10, 8'h28, 1'b0);
    runRead("R5 odd limit", 16'd5121, 32'd62, 16'd3, 8'h28, 1'b1);
    runRead("R6 zero limit", 16'd0, 32'd5, 16'd33, 8'h28, 1'b0);
    runRead("R10 zero count", 16'd5120, 32'd1, 16'd0, 8'h28, 1'b0);
    runRead("R10 other opcode", 16'd5120, 32'd1, 16'd2, 8'h12, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule